// File: doc/BRIEF.md
# Calendar-Style Elapsed-Time Counter with Snapshot Readout

This block keeps elapsed time as seconds, minutes, hours and a 9-bit day count. The live counters advance on a divided base tick. Software reads time through five 8-bit register indices, and every read returns a frozen copy rather than the moving counters. A latch pulse copies the live counters into that copy, and the copy then holds until the next latch pulse. Reading several fields in a row therefore never mixes values from either side of a rollover.

Software can write any field directly. A status register carries three things: the ninth day bit, a halt control that freezes the clock, and a sticky flag that records that the day count wrapped. The base tick enters as an enable pulse. An internal prescaler divides it by `SUBTICKS` to form the one-second step. With `SUBTICKS` set to 1, the input itself serves as the seconds tick.

Top module: `rtc_snapshot_clock`

## Requirements
- R1: After synchronous reset, every time register reads 0x00 and the clock is running (halt bit clear).
- R2: While running, the seconds field advances by exactly one after every `SUBTICKS` cycles with `tick` high, counting only those cycles.
- R3: A step from second 59 sets seconds to 0 and carries into minutes. Minute 59 carries into hours, and hour 23 carries into the day count. The whole carry chain completes in the same cycle.
- R4: The day count is 9 bits wide. Index 0x0B holds its low 8 bits, and bit 0 of index 0x0C holds bit 8. A carry into day 511 wraps the count to 0 and sets bit 7 of index 0x0C.
- R5: Bit 7 of index 0x0C stays set through later steps. Only a write to 0x0C changes it, and the written bit 7 becomes its new value. A write in the same cycle as a wrapping step takes priority for that bit.
- R6: When bit 6 of index 0x0C is 1, `tick` is ignored: neither the counters nor the prescaler move.
- R7: `rd_data` reflects the copy taken at the most recent latch pulse. Index 0x08 is seconds, 0x09 minutes, 0x0A hours, 0x0B day low and 0x0C flags. The copy holds until the next latch pulse. Any other index reads 0x00.
- R8: A write updates the live counters, and the new value becomes visible after the next latch. When a write coincides with a step, the written field takes the write data and the other fields follow the step. A write to seconds cancels any step in its cycle.
- R9: Bits 1 to 5 of index 0x0C read as 0, and writes to those bits are ignored.
- R10: A write to seconds clears the prescaler, so the next step comes only after a further `SUBTICKS` tick cycles.
- R11: A latch pulse captures the counters as they stood before that clock edge, even when a step or a write lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick enable, divided by SUBTICKS into seconds |
| latch_pulse | input | 1 | Copy live counters into the read snapshot |
| reg_sel | input | 8 | Register index for read and write (0x08 to 0x0C) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected field of the latched snapshot |

## Verification
Three pairs of functions can land in the same cycle:
- a seconds step with a write;
- a latch with a step or a write;
- a wrapping day carry with a software write to the flag register.

The bench drives these pairs in a single cycle. It holds the prescaler one tick short of a step and then drives `tick` together with `wr_en` or `latch_pulse`. A behavioural model applies the stated priority: the latch takes pre-edge values, the step comes next, and the write overrides last. A flag write that coincides with a day wrap must leave the written carry and day-bit-8 values in place. Hand-computed register reads and a model comparison on every cycle judge the outcome.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_W = 8;
    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int DAY_W = 9;

    localparam logic [SEC_W-1:0] SEC_MAX = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_MAX = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_MAX  = HR_W'(23);
    localparam logic [DAY_W-1:0] DAY_MAX = '1;

    localparam logic [REG_W-1:0] IDX_SEC    = 8'h08;
    localparam logic [REG_W-1:0] IDX_MIN    = 8'h09;
    localparam logic [REG_W-1:0] IDX_HR     = 8'h0A;
    localparam logic [REG_W-1:0] IDX_DAY_LO = 8'h0B;
    localparam logic [REG_W-1:0] IDX_FLAGS  = 8'h0C;

    localparam int FLAG_DAY8_BIT  = 0;
    localparam int FLAG_HALT_BIT  = 6;
    localparam int FLAG_CARRY_BIT = 7;

    typedef struct packed {
        logic             carry;
        logic             halt;
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } rtc_time_t;

    // One-second step with the full carry chain.
    function automatic rtc_time_t rtc_advance(rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != SEC_MAX) begin
            n.sec = t.sec + SEC_W'(1);
        end else begin
            n.sec = '0;
            if (t.min != MIN_MAX) begin
                n.min = t.min + MIN_W'(1);
            end else begin
                n.min = '0;
                if (t.hr != HR_MAX) begin
                    n.hr = t.hr + HR_W'(1);
                end else begin
                    n.hr = '0;
                    if (t.day != DAY_MAX) begin
                        n.day = t.day + DAY_W'(1);
                    end else begin
                        n.day   = '0;
                        n.carry = 1'b1;
                    end
                end
            end
        end
        return n;
    endfunction

    // Overlay a software write onto one field.
    function automatic rtc_time_t rtc_apply_write(rtc_time_t t,
                                                  logic [REG_W-1:0] idx,
                                                  logic [REG_W-1:0] d);
        rtc_time_t n;
        n = t;
        case (idx)
            IDX_SEC:    n.sec = d[SEC_W-1:0];
            IDX_MIN:    n.min = d[MIN_W-1:0];
            IDX_HR:     n.hr  = d[HR_W-1:0];
            IDX_DAY_LO: n.day[REG_W-1:0] = d;
            IDX_FLAGS: begin
                n.day[DAY_W-1] = d[FLAG_DAY8_BIT];
                n.halt         = d[FLAG_HALT_BIT];
                n.carry        = d[FLAG_CARRY_BIT];
            end
            default: ;
        endcase
        return n;
    endfunction

    function automatic logic [REG_W-1:0] rtc_read_reg(rtc_time_t t,
                                                      logic [REG_W-1:0] idx);
        logic [REG_W-1:0] r;
        r = '0;
        case (idx)
            IDX_SEC:    r = REG_W'(t.sec);
            IDX_MIN:    r = REG_W'(t.min);
            IDX_HR:     r = REG_W'(t.hr);
            IDX_DAY_LO: r = t.day[REG_W-1:0];
            IDX_FLAGS: begin
                r[FLAG_DAY8_BIT]  = t.day[DAY_W-1];
                r[FLAG_HALT_BIT]  = t.halt;
                r[FLAG_CARRY_BIT] = t.carry;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int SUBTICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic clr,
    output logic sec_pulse
);
    localparam int CNT_W = (SUBTICKS > 1) ? $clog2(SUBTICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SUBTICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    assign adv       = tick && run && !clr;
    assign sec_pulse = adv && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rtc_live_counters.sv
module rtc_live_counters
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_pulse,
    input  logic             wr_en,
    input  logic [REG_W-1:0] reg_sel,
    input  logic [REG_W-1:0] wr_data,
    output rtc_time_t        live_q
);
    rtc_time_t stepped;
    rtc_time_t nxt;

    always_comb begin
        stepped = sec_pulse ? rtc_advance(live_q) : live_q;
        nxt     = wr_en ? rtc_apply_write(stepped, reg_sel, wr_data) : stepped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else begin
            live_q <= nxt;
        end
    end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_pulse,
    input  rtc_time_t        live_q,
    input  logic [REG_W-1:0] reg_sel,
    output rtc_time_t        snap_q,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (latch_pulse) begin
            snap_q <= live_q;
        end
    end

    assign rd_data = rtc_read_reg(snap_q, reg_sel);
endmodule

// File: rtl/rtc_snapshot_clock.sv
module rtc_snapshot_clock
    import rtc_pkg::*;
#(
    parameter int SUBTICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             latch_pulse,
    input  logic [REG_W-1:0] reg_sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    rtc_time_t live_q;
    rtc_time_t snap_q;
    logic      sec_pulse;
    logic      sec_write;

    assign sec_write = wr_en && (reg_sel == IDX_SEC);

    rtc_prescaler #(.SUBTICKS(SUBTICKS)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run       (!live_q.halt),
        .clr       (sec_write),
        .sec_pulse (sec_pulse)
    );

    rtc_live_counters u_live (
        .clk       (clk),
        .rst       (rst),
        .sec_pulse (sec_pulse),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .live_q    (live_q)
    );

    rtc_snapshot u_snap (
        .clk         (clk),
        .rst         (rst),
        .latch_pulse (latch_pulse),
        .live_q      (live_q),
        .reg_sel     (reg_sel),
        .snap_q      (snap_q),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/rtc_snapshot_clock_chk.sv
module rtc_snapshot_clock_chk
    import rtc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             latch_pulse,
    input logic [REG_W-1:0] reg_sel,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input rtc_time_t        live_q,
    input rtc_time_t        snap_q,
    input logic             sec_pulse
);
    // R7: the snapshot only moves on a latch pulse
    a_r7_snapshot_holds: assert property (@(posedge clk) disable iff (rst)
        !latch_pulse |=> $stable(snap_q));

    // R11: the latch takes the pre-edge live value
    a_r11_latch_captures: assert property (@(posedge clk) disable iff (rst)
        latch_pulse |=> (snap_q == $past(live_q)));

    // R6: a halted clock with no write stays put
    a_r6_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (live_q.halt && !wr_en) |=> $stable(live_q));

    // R5: the carry flag survives steps
    a_r5_carry_sticky: assert property (@(posedge clk) disable iff (rst)
        (live_q.carry && !wr_en) |=> live_q.carry);

    // R4: the top of the day range wraps and raises carry
    a_r4_day_wrap: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && !wr_en && live_q.day == DAY_MAX && live_q.hr == HR_MAX
         && live_q.min == MIN_MAX && live_q.sec == SEC_MAX)
        |=> (live_q.day == '0 && live_q.carry && live_q.sec == '0));

    // R8: a seconds write lands exactly
    a_r8_sec_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == IDX_SEC) |=> (live_q.sec == $past(wr_data[SEC_W-1:0])));

    // R9: reserved flag bits read as zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == IDX_FLAGS) |-> (rd_data[5:1] == 5'd0));
endmodule

bind rtc_snapshot_clock rtc_snapshot_clock_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .latch_pulse (latch_pulse),
    .reg_sel     (reg_sel),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .live_q      (live_q),
    .snap_q      (snap_q),
    .sec_pulse   (sec_pulse)
);

// File: tb/rtc_snapshot_clock_tb.sv
module rtc_snapshot_clock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SUB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       latch_pulse = 1'b0;
    logic [7:0] reg_sel = 8'h08;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;

    // behavioural reference state
    int m_sec, m_min, m_hr, m_day, m_halt, m_carry, m_pre;
    int l_sec, l_min, l_hr, l_day, l_halt, l_carry;
    bit m_step;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_snapshot_clock #(.SUBTICKS(SUB)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .latch_pulse (latch_pulse),
        .reg_sel     (reg_sel),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_halt = 0; m_carry = 0; m_pre = 0;
            l_sec = 0; l_min = 0; l_hr = 0; l_day = 0; l_halt = 0; l_carry = 0;
        end else begin
            if (latch_pulse) begin
                l_sec = m_sec; l_min = m_min; l_hr = m_hr;
                l_day = m_day; l_halt = m_halt; l_carry = m_carry;
            end
            m_step = 1'b0;
            if (wr_en && reg_sel == 8'h08) m_pre = 0;
            else if (tick && m_halt == 0) begin
                if (m_pre == SUB - 1) begin m_pre = 0; m_step = 1'b1; end
                else m_pre = m_pre + 1;
            end
            if (m_step) begin
                m_sec = m_sec + 1;
                if (m_sec == 60) begin
                    m_sec = 0; m_min = m_min + 1;
                    if (m_min == 60) begin
                        m_min = 0; m_hr = m_hr + 1;
                        if (m_hr == 24) begin
                            m_hr = 0; m_day = m_day + 1;
                            if (m_day == 512) begin m_day = 0; m_carry = 1; end
                        end
                    end
                end
            end
            if (wr_en) begin
                case (reg_sel)
                    8'h08: m_sec = wr_data & 63;
                    8'h09: m_min = wr_data & 63;
                    8'h0A: m_hr  = wr_data & 31;
                    8'h0B: m_day = (m_day & 256) | wr_data;
                    8'h0C: begin
                        m_day   = (m_day & 255) | ((wr_data & 1) << 8);
                        m_halt  = wr_data[6];
                        m_carry = wr_data[7];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic int model_read(logic [7:0] sel);
        case (sel)
            8'h08: return l_sec;
            8'h09: return l_min;
            8'h0A: return l_hr;
            8'h0B: return l_day & 255;
            8'h0C: return (l_carry << 7) | (l_halt << 6) | (l_day >> 8);
            default: return 0;
        endcase
    endfunction

    // R7: per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (started && !rst) begin
            checks = checks + 1;
            if (int'(rd_data) != model_read(reg_sel)) begin
                failures = failures + 1;
                $display("FAIL R7 model sel=%h actual=%h expected=%h",
                         reg_sel, rd_data, model_read(reg_sel));
            end
        end
    end

    task automatic drive(input bit t, input bit l, input logic [7:0] s,
                         input bit w, input logic [7:0] d);
        @(posedge clk); #1;
        tick = t; latch_pulse = l; reg_sel = s; wr_en = w; wr_data = d;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        drive(0, 0, idx, 1, val);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1, 0, reg_sel, 0, 0);
    endtask

    task automatic do_latch();
        drive(0, 1, reg_sel, 0, 0);
    endtask

    task automatic expect_reg(input logic [7:0] idx, input logic [7:0] exp,
                              input string tag);
        drive(0, 0, idx, 0, 0);
        @(negedge clk);
        #1;
        checks = checks + 1;
        if (rd_data !== exp) begin
            failures = failures + 1;
            $display("FAIL %s idx=%h actual=%h expected=%h", tag, idx, rd_data, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] dlo, input logic [7:0] flags,
                            input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        wr(8'h0B, dlo); wr(8'h0C, flags); wr(8'h0A, h); wr(8'h09, mi); wr(8'h08, s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures = failures + 1;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        started = 1'b1;

        // R1: reset state
        expect_reg(8'h08, 8'h00, "R1 sec");
        expect_reg(8'h09, 8'h00, "R1 min");
        expect_reg(8'h0A, 8'h00, "R1 hr");
        expect_reg(8'h0B, 8'h00, "R1 daylo");
        expect_reg(8'h0C, 8'h00, "R1 flags");

        // R2: one step per SUB ticks
        ticks(SUB); do_latch();
        expect_reg(8'h08, 8'h01, "R2 first step");
        ticks(SUB - 1); do_latch();
        expect_reg(8'h08, 8'h01, "R2 partial");
        ticks(1); do_latch();
        expect_reg(8'h08, 8'h02, "R2 second step");

        // R7: snapshot holds without latch
        ticks(2 * SUB);
        expect_reg(8'h08, 8'h02, "R7 hold");
        do_latch();
        expect_reg(8'h08, 8'h04, "R7 relatch");
        expect_reg(8'h07, 8'h00, "R7 index below");
        expect_reg(8'h0D, 8'h00, "R7 index above");

        // R3: full cascade in one step
        wr(8'h0A, 23); wr(8'h09, 59); wr(8'h08, 59); wr(8'h0B, 5);
        ticks(SUB); do_latch();
        expect_reg(8'h08, 8'h00, "R3 sec");
        expect_reg(8'h09, 8'h00, "R3 min");
        expect_reg(8'h0A, 8'h00, "R3 hr");
        expect_reg(8'h0B, 8'h06, "R3 day");

        // R4: day wrap sets carry
        set_time(8'hFF, 8'h01, 23, 59, 59);
        ticks(SUB); do_latch();
        expect_reg(8'h0B, 8'h00, "R4 daylo");
        expect_reg(8'h0C, 8'h80, "R4 flags");
        // R5: sticky, then cleared and set by writes
        ticks(SUB); do_latch();
        expect_reg(8'h0C, 8'h80, "R5 sticky");
        wr(8'h0C, 8'h00); do_latch();
        expect_reg(8'h0C, 8'h00, "R5 cleared");
        wr(8'h0C, 8'h80); do_latch();
        expect_reg(8'h0C, 8'h80, "R5 set by write");

        // R9: reserved bits
        wr(8'h0C, 8'h3E); do_latch();
        expect_reg(8'h0C, 8'h00, "R9 reserved only");
        wr(8'h0C, 8'hFF); do_latch();
        expect_reg(8'h0C, 8'hC1, "R9 all ones");
        wr(8'h0C, 8'h00);

        // R6: halt freezes
        wr(8'h08, 10); wr(8'h0C, 8'h40);
        ticks(3 * SUB); do_latch();
        expect_reg(8'h08, 8'd10, "R6 frozen sec");
        expect_reg(8'h0C, 8'h40, "R6 halt bit");
        wr(8'h0C, 8'h00);
        ticks(SUB); do_latch();
        expect_reg(8'h08, 8'd11, "R6 resumed");

        // R10: seconds write restarts prescaler
        ticks(2); wr(8'h08, 30);
        ticks(SUB - 1); do_latch();
        expect_reg(8'h08, 8'd30, "R10 no early step");
        ticks(1); do_latch();
        expect_reg(8'h08, 8'd31, "R10 full second");

        // R8: write coinciding with a step
        ticks(SUB - 1);
        drive(1, 0, 8'h09, 1, 8'd7);
        do_latch();
        expect_reg(8'h08, 8'd32, "R8 step kept");
        expect_reg(8'h09, 8'd7, "R8 write kept");
        ticks(SUB - 1);
        drive(1, 0, 8'h08, 1, 8'd59);
        ticks(SUB - 1); do_latch();
        expect_reg(8'h08, 8'd59, "R8 sec write cancels step");
        expect_reg(8'h09, 8'd7, "R8 no carry");
        ticks(1); do_latch();
        expect_reg(8'h09, 8'd8, "R8 later carry");

        // R11: latch coinciding with step and with write
        ticks(SUB - 1);
        drive(1, 1, 8'h08, 0, 0);
        expect_reg(8'h08, 8'd0, "R11 pre-step capture");
        do_latch();
        expect_reg(8'h08, 8'd1, "R11 post-step");
        drive(0, 1, 8'h09, 1, 8'd20);
        expect_reg(8'h09, 8'd8, "R11 pre-write capture");
        do_latch();
        expect_reg(8'h09, 8'd20, "R11 post-write");

        // R5: flag write beats a coincident day wrap
        set_time(8'hFF, 8'h01, 23, 59, 59);
        ticks(SUB - 1);
        drive(1, 0, 8'h0C, 1, 8'h01);
        do_latch();
        expect_reg(8'h0C, 8'h01, "R5 write over wrap");
        expect_reg(8'h0B, 8'h00, "R5 day low from step");
        expect_reg(8'h0A, 8'h00, "R5 hr from step");

        drive(0, 0, 8'h08, 0, 0);
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule